// File: doc/BRIEF.md
# Low-Power Wakeup Event Controller

This block watches two groups of general-purpose input pins and three internal event sources and records every wakeup event as a sticky flag. Each pin input is brought into the clock domain through a synchronizer. A change of level in either direction then sets that pin's flag. Software reads the flags over a small register bus and clears them by writing ones.

A single registered interrupt line, `wake_irq`, tells the power controller that a wakeup is pending. A pin flag counts toward the interrupt only when its per-pin enable bit is set and the global GPIO wake enable input is high. The three peripheral flags always count toward it. The three peripheral sources are exit from battery backup, wakeup by external reset, and a level change on a DMA interrupt line.

Top module: `wkup_ctrl`

## Requirements
- R1: After synchronous reset, every status flag, every enable bit, `wake_irq` and `reg_rdata` are 0.
- R2: A level change of either polarity on a group-A pin (16 pins) sets that pin's bit in the group-A status register (address 0x04, bit n = pin n). The flag is set on the third rising clock edge after the change: two synchronizer flops, then the edge compare.
- R3: Group B has 11 pins, with status at 0x0C and enable at 0x10. Bits 31:11 of both registers read 0, and writes to those bits are ignored.
- R4: Writing 1 to a status bit clears it. Writing 0 leaves it unchanged. A status flag falls only on such a write.
- R5: If a new event and a write-1 clear reach the same status bit in the same cycle, the bit stays set.
- R6: The per-pin enable registers are read/write, at address 0x08 for group A and 0x10 for group B, and reset to 0.
- R7: `wake_irq` is a register. It is 1 one cycle after any pin flag is set together with its enable bit while `gpio_wake_en` is 1, or after any peripheral flag is set. It is 0 when there is no such cause.
- R8: The peripheral status register is at 0x30. Bit 16 is set by a one-cycle `bbk_exit_pulse`. Bit 17 is set by a one-cycle `ext_rst_pulse`. Bit 18 is set when the synchronized `dma_irq` changes level. All three bits are write-1-to-clear. They drive `wake_irq` whatever the state of `gpio_wake_en`.
- R9: A read strobe returns data on `reg_rdata` one cycle later. In cycles with no read, `reg_rdata` is 0. Unmapped addresses read 0, and writes to them change nothing.
- R10: `wake_irq` stays high until every flag that contributes to it has been cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| grp_a_pins | input | 16 | Group-A wake-capable pins (asynchronous) |
| grp_b_pins | input | 11 | Group-B wake-capable pins (asynchronous) |
| gpio_wake_en | input | 1 | Global enable for pin-sourced wakeup interrupts |
| bbk_exit_pulse | input | 1 | One-cycle pulse on leaving battery backup |
| ext_rst_pulse | input | 1 | One-cycle pulse when an external reset causes wakeup |
| dma_irq | input | 1 | DMA interrupt line, watched for level changes |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | 32 | Write data |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_rdata | output | 32 | Read data, valid one cycle after the read strobe |
| wake_irq | output | 1 | Registered wakeup interrupt |

## Verification
The bench builds the block with its defaults: 16 group-A pins, 11 group-B pins and two synchronizer stages. These defaults put the group-B bits 31:11 within reach, so the bench can check that they read as zero. Random pin patterns, held for single cycles, toggle each pin several times. This gives both edge polarities, back-to-back edges and random partial clears. Directed cases then time a write-1 clear to land exactly on the cycle a new edge is recorded, and hold the interrupt with one peripheral flag while another is cleared.

// File: rtl/wkup_pkg.sv
package wkup_pkg;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 8;

    localparam logic [ADDR_W-1:0] ADDR_A_ST  = 8'h04;
    localparam logic [ADDR_W-1:0] ADDR_A_EN  = 8'h08;
    localparam logic [ADDR_W-1:0] ADDR_B_ST  = 8'h0C;
    localparam logic [ADDR_W-1:0] ADDR_B_EN  = 8'h10;
    localparam logic [ADDR_W-1:0] ADDR_PER   = 8'h30;

    localparam int PER_BBK_BIT  = 16;
    localparam int PER_XRST_BIT = 17;
    localparam int PER_DMA_BIT  = 18;
    localparam int PER_W        = 3;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_A_ST,
        SEL_A_EN,
        SEL_B_ST,
        SEL_B_EN,
        SEL_PER
    } reg_sel_e;

    typedef struct packed {
        logic dma;
        logic xrst;
        logic bbk;
    } per_evt_t;

    function automatic reg_sel_e decode_addr(input logic [ADDR_W-1:0] a);
        case (a)
            ADDR_A_ST: return SEL_A_ST;
            ADDR_A_EN: return SEL_A_EN;
            ADDR_B_ST: return SEL_B_ST;
            ADDR_B_EN: return SEL_B_EN;
            ADDR_PER:  return SEL_PER;
            default:   return SEL_NONE;
        endcase
    endfunction

    function automatic per_evt_t per_from_word(input logic [DATA_W-1:0] w);
        per_evt_t p;
        p.bbk  = w[PER_BBK_BIT];
        p.xrst = w[PER_XRST_BIT];
        p.dma  = w[PER_DMA_BIT];
        return p;
    endfunction

    function automatic logic [DATA_W-1:0] per_to_word(input per_evt_t p);
        logic [DATA_W-1:0] w;
        w = '0;
        w[PER_BBK_BIT]  = p.bbk;
        w[PER_XRST_BIT] = p.xrst;
        w[PER_DMA_BIT]  = p.dma;
        return w;
    endfunction
endpackage

// File: rtl/wkup_sync.sv
module wkup_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= '0;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/wkup_toggle_det.sv
module wkup_toggle_det #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] lvl,
    output logic [W-1:0] tog
);
    logic [W-1:0] prev;

    always_ff @(posedge clk) begin
        if (rst) prev <= '0;
        else     prev <= lvl;
    end

    assign tog = lvl ^ prev;
endmodule

// File: rtl/wkup_flag_reg.sv
module wkup_flag_reg #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] set,
    input  logic [W-1:0] clr,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= (q & ~clr) | set;
    end

    for (genvar i = 0; i < W; i++) begin : g_chk
        // R5: an event always lands, even against a same-cycle clear
        assert_set_wins_R5: assert property (@(posedge clk) disable iff (rst)
            set[i] |=> q[i]);
        // R4: a flag only falls after a write-1 clear
        assert_fall_needs_clear_R4: assert property (@(posedge clk) disable iff (rst)
            $fell(q[i]) |-> $past(clr[i]));
    end
endmodule

// File: rtl/wkup_ctrl.sv
module wkup_ctrl
    import wkup_pkg::*;
#(
    parameter int A_PINS      = 16,
    parameter int B_PINS      = 11,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [A_PINS-1:0] grp_a_pins,
    input  logic [B_PINS-1:0] grp_b_pins,
    input  logic              gpio_wake_en,
    input  logic              bbk_exit_pulse,
    input  logic              ext_rst_pulse,
    input  logic              dma_irq,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic              reg_wr,
    input  logic              reg_rd,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              wake_irq
);
    localparam int IN_W = A_PINS + B_PINS + 1;

    logic [IN_W-1:0] raw_in, sync_in, tog_in;
    logic [A_PINS-1:0] a_st, a_en, a_clr;
    logic [B_PINS-1:0] b_st, b_en, b_clr;
    per_evt_t per_st, per_set, per_clr;
    reg_sel_e sel;
    logic [DATA_W-1:0] rd_mux;
    logic pin_cause;

    assign raw_in = {dma_irq, grp_b_pins, grp_a_pins};

    wkup_sync #(.W(IN_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .d(raw_in), .q(sync_in)
    );

    wkup_toggle_det #(.W(IN_W)) u_tog (
        .clk(clk), .rst(rst), .lvl(sync_in), .tog(tog_in)
    );

    assign sel = decode_addr(reg_addr);

    always_comb begin
        a_clr   = '0;
        b_clr   = '0;
        per_clr = '0;
        if (reg_wr) begin
            case (sel)
                SEL_A_ST: a_clr   = reg_wdata[A_PINS-1:0];
                SEL_B_ST: b_clr   = reg_wdata[B_PINS-1:0];
                SEL_PER:  per_clr = per_from_word(reg_wdata);
                default: ;
            endcase
        end
    end

    always_comb begin
        per_set.bbk  = bbk_exit_pulse;
        per_set.xrst = ext_rst_pulse;
        per_set.dma  = tog_in[IN_W-1];
    end

    wkup_flag_reg #(.W(A_PINS)) u_a_flags (
        .clk(clk), .rst(rst), .set(tog_in[A_PINS-1:0]), .clr(a_clr), .q(a_st)
    );

    wkup_flag_reg #(.W(B_PINS)) u_b_flags (
        .clk(clk), .rst(rst), .set(tog_in[A_PINS +: B_PINS]), .clr(b_clr), .q(b_st)
    );

    wkup_flag_reg #(.W(PER_W)) u_per_flags (
        .clk(clk), .rst(rst), .set(per_set), .clr(per_clr), .q(per_st)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            a_en <= '0;
            b_en <= '0;
        end else if (reg_wr) begin
            if (sel == SEL_A_EN) a_en <= reg_wdata[A_PINS-1:0];
            if (sel == SEL_B_EN) b_en <= reg_wdata[B_PINS-1:0];
        end
    end

    always_comb begin
        rd_mux = '0;
        case (sel)
            SEL_A_ST: rd_mux[A_PINS-1:0] = a_st;
            SEL_A_EN: rd_mux[A_PINS-1:0] = a_en;
            SEL_B_ST: rd_mux[B_PINS-1:0] = b_st;
            SEL_B_EN: rd_mux[B_PINS-1:0] = b_en;
            SEL_PER:  rd_mux = per_to_word(per_st);
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)         reg_rdata <= '0;
        else if (reg_rd) reg_rdata <= rd_mux;
        else             reg_rdata <= '0;
    end

    assign pin_cause = gpio_wake_en & ((|(a_st & a_en)) | (|(b_st & b_en)));

    always_ff @(posedge clk) begin
        if (rst) wake_irq <= 1'b0;
        else     wake_irq <= pin_cause | (|per_st);
    end

    // R7: no cause means no interrupt on the next cycle
    assert_irq_quiet_R7: assert property (@(posedge clk) disable iff (rst)
        (!gpio_wake_en && per_st == '0) |=> !wake_irq);
    // R8: battery-backup exit always raises its flag
    assert_bbk_flag_R8: assert property (@(posedge clk) disable iff (rst)
        bbk_exit_pulse |=> per_st.bbk);
    // R9: bus data is zero outside read cycles
    assert_rdata_idle_R9: assert property (@(posedge clk) disable iff (rst)
        !reg_rd |=> reg_rdata == '0);
    // R3: group-B upper bits never appear
    assert_b_upper_zero_R3: assert property (@(posedge clk) disable iff (rst)
        (reg_rd && (reg_addr == ADDR_B_ST || reg_addr == ADDR_B_EN))
        |=> reg_rdata[DATA_W-1:B_PINS] == '0);
endmodule

// File: tb/wkup_ctrl_test.sv
module wkup_ctrl_test;
    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic        rst;
    logic [15:0] grp_a_pins;
    logic [10:0] grp_b_pins;
    logic        gpio_wake_en, bbk_exit_pulse, ext_rst_pulse, dma_irq;
    logic [7:0]  reg_addr;
    logic [31:0] reg_wdata;
    logic        reg_wr, reg_rd;
    logic [31:0] reg_rdata;
    logic        wake_irq;

    wkup_ctrl uut (
        .clk(clk), .rst(rst), .grp_a_pins(grp_a_pins), .grp_b_pins(grp_b_pins),
        .gpio_wake_en(gpio_wake_en), .bbk_exit_pulse(bbk_exit_pulse),
        .ext_rst_pulse(ext_rst_pulse), .dma_irq(dma_irq), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_rdata(reg_rdata), .wake_irq(wake_irq)
    );

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [15:0] m_a_st, m_a_en;
    logic [10:0] m_b_st, m_b_en;
    logic [2:0]  m_per;
    logic [31:0] rv;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        @(negedge clk);
        reg_rd = 1'b0;
        d = reg_rdata;
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic apply_pins(input logic [15:0] a, input logic [10:0] b);
        @(negedge clk);
        m_a_st |= a ^ grp_a_pins;
        m_b_st |= b ^ grp_b_pins;
        grp_a_pins = a;
        grp_b_pins = b;
    endtask

    function automatic logic exp_irq();
        return (gpio_wake_en & ((|(m_a_st & m_a_en)) | (|(m_b_st & m_b_en)))) | (|m_per);
    endfunction

    task automatic check_all(input string tag);
        bus_rd(8'h04, rv); check({tag, " R2 group A status"}, rv, {16'h0, m_a_st});
        bus_rd(8'h0C, rv); check({tag, " R3 group B status"}, rv, {21'h0, m_b_st});
        bus_rd(8'h30, rv); check({tag, " R8 peripheral status"}, rv, {13'h0, m_per, 16'h0});
        check({tag, " R7 wake_irq"}, {31'h0, wake_irq}, {31'h0, exp_irq()});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2718));
        rst = 1'b1;
        grp_a_pins = '0; grp_b_pins = '0;
        gpio_wake_en = 1'b0; bbk_exit_pulse = 1'b0; ext_rst_pulse = 1'b0; dma_irq = 1'b0;
        reg_addr = '0; reg_wdata = '0; reg_wr = 1'b0; reg_rd = 1'b0;
        m_a_st = '0; m_a_en = '0; m_b_st = '0; m_b_en = '0; m_per = '0;
        settle(4);
        rst = 1'b0;
        settle(1);

        // R1: reset state
        check("R1 rdata after reset", reg_rdata, 32'h0);
        check("R1 irq after reset", {31'h0, wake_irq}, 32'h0);
        bus_rd(8'h04, rv); check("R1 group A status", rv, 32'h0);
        bus_rd(8'h08, rv); check("R1 R6 group A enable", rv, 32'h0);
        bus_rd(8'h0C, rv); check("R1 group B status", rv, 32'h0);
        bus_rd(8'h10, rv); check("R1 R6 group B enable", rv, 32'h0);
        bus_rd(8'h30, rv); check("R1 peripheral status", rv, 32'h0);

        // R2: exact latency of a rising edge (flag visible after third edge)
        apply_pins(16'h0001, '0);
        @(negedge clk); @(negedge clk);
        bus_rd(8'h04, rv); check("R2 rising edge flag", rv, 32'h1);
        bus_wr(8'h04, 32'h1); m_a_st = '0;
        apply_pins(16'h0000, '0);
        settle(4);
        bus_rd(8'h04, rv); check("R2 falling edge flag", rv, 32'h1);

        // R4: write 0 keeps, write 1 clears
        bus_wr(8'h04, 32'h0);
        bus_rd(8'h04, rv); check("R4 write zero keeps", rv, 32'h1);
        bus_wr(8'h04, 32'h1); m_a_st = '0;
        bus_rd(8'h04, rv); check("R4 write one clears", rv, 32'h0);

        // R6, R3: enable registers, group B width
        bus_wr(8'h10, 32'hFFFF_FFFF); m_b_en = 11'h7FF;
        bus_rd(8'h10, rv); check("R3 R6 group B enable upper bits", rv, 32'h0000_07FF);
        bus_wr(8'h08, 32'hFFFF_A5C3); m_a_en = 16'hA5C3;
        bus_rd(8'h08, rv); check("R6 group A enable", rv, 32'h0000_A5C3);
        apply_pins('0, 11'h400);
        settle(4);
        bus_wr(8'h0C, 32'hFFFF_F800);
        bus_rd(8'h0C, rv); check("R3 upper write ignored", rv, 32'h0000_0400);

        // R7: global enable gates pin interrupts
        gpio_wake_en = 1'b0;
        settle(2);
        check("R7 irq gated by global", {31'h0, wake_irq}, 32'h0);
        gpio_wake_en = 1'b1;
        @(negedge clk);
        check("R7 irq one cycle after enable", {31'h0, wake_irq}, 32'h1);
        bus_wr(8'h0C, 32'h400); m_b_st = '0;
        settle(1);
        check("R7 irq drops after clear", {31'h0, wake_irq}, 32'h0);

        // R5: edge recorded in the same cycle as a clear
        apply_pins(16'h0002, '0);
        @(negedge clk);
        bus_wr(8'h04, 32'h2);
        settle(2);
        bus_rd(8'h04, rv); check("R5 set wins over clear", rv, 32'h2);
        bus_wr(8'h04, 32'h2); m_a_st = '0;
        bus_rd(8'h04, rv); check("R5 later clear works", rv, 32'h0);

        // R9: unmapped address
        bus_wr(8'h20, 32'hFFFF_FFFF);
        bus_rd(8'h20, rv); check("R9 unmapped reads zero", rv, 32'h0);
        bus_rd(8'h08, rv); check("R9 unmapped write no effect", rv, 32'h0000_A5C3);

        // R8, R10: peripheral flags
        gpio_wake_en = 1'b0;
        @(negedge clk); bbk_exit_pulse = 1'b1;
        @(negedge clk); bbk_exit_pulse = 1'b0; ext_rst_pulse = 1'b1;
        @(negedge clk); ext_rst_pulse = 1'b0;
        m_per = 3'b011;
        settle(1);
        check("R8 irq without global enable", {31'h0, wake_irq}, 32'h1);
        bus_rd(8'h30, rv); check("R8 bbk and reset flags", rv, 32'h0003_0000);
        bus_wr(8'h30, 32'h0001_0000); m_per = 3'b010;
        settle(1);
        check("R10 irq held by remaining flag", {31'h0, wake_irq}, 32'h1);
        bus_wr(8'h30, 32'h0002_0000); m_per = 3'b000;
        settle(1);
        check("R10 irq falls after last clear", {31'h0, wake_irq}, 32'h0);
        dma_irq = 1'b1;
        settle(4);
        bus_rd(8'h30, rv); check("R8 dma rise flag", rv, 32'h0004_0000);
        bus_wr(8'h30, 32'h0004_0000);
        dma_irq = 1'b0;
        settle(4);
        bus_rd(8'h30, rv); check("R8 dma fall flag", rv, 32'h0004_0000);
        bus_wr(8'h30, 32'h0004_0000);
        settle(2);

        // Random mix: R2 R3 R4 R7
        for (int it = 0; it < 40; it++) begin
            gpio_wake_en = $urandom() % 2;
            m_a_en = $urandom(); m_b_en = $urandom();
            bus_wr(8'h08, {16'h0, m_a_en});
            bus_wr(8'h10, {21'h0, m_b_en});
            for (int k = 0; k < 3; k++) apply_pins($urandom(), $urandom());
            settle(5);
            check_all("rand set");
            begin
                logic [15:0] ca;
                logic [10:0] cb;
                ca = $urandom(); cb = $urandom();
                bus_wr(8'h04, {16'h0, ca}); m_a_st &= ~ca;
                bus_wr(8'h0C, {21'h0, cb}); m_b_st &= ~cb;
            end
            settle(1);
            check_all("rand clear R4");
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule